// File: doc/BRIEF.md
# Eight-Output Addressable Latch

This block stores eight single-bit values and lets them be written one at a time. A data bit is routed to one of the eight output bits, chosen by a 3-bit address. An active-low enable decides whether writing takes place, and an active-low clear forces bits to zero. Together the enable and the clear select one of four behaviours:

- **Addressable write:** one bit loads data and the other bits keep their values.
- **Hold:** every bit keeps its value, whatever the data and address lines do.
- **Clear-all:** every bit is forced to zero.
- **One-of-eight decode:** the addressed bit follows data and the other bits are forced to zero.

The block is fully synchronous. All four control and data inputs are sampled on the rising edge of the system clock. The outputs change on that same edge, so each result is visible one clock edge after the stimulus is applied. While the enable is low, the addressed bit follows data on every edge. When the enable returns high, the bit keeps the data value from the last edge at which the enable was still low. A separate active-high synchronous reset empties the store at power-up. Address changes are only expected while the enable is high.

Top module: `addressable_latch`

## Requirements
- R1: Output bit `latchOut[i]` is the cell selected when `addrIn` equals i, with `addrIn` read as an unsigned binary number (bit 0 is the least significant bit).
- R2: With `enableN`=0 and `clearN`=1 at a rising edge, `latchOut[addrIn]` takes `dataIn` at that edge, and every other bit keeps its value.
- R3: After `enableN` returns to 1, the bit that was addressed keeps the `dataIn` value sampled at the last edge where `enableN` was 0, even if `dataIn` changes afterwards.
- R4: With `enableN`=1 and `clearN`=1 at a rising edge, all eight bits keep their values, whatever `dataIn` and `addrIn` do.
- R5: With `enableN`=1 and `clearN`=0 at a rising edge, all eight bits become 0.
- R6: With `enableN`=0 and `clearN`=0 at a rising edge, `latchOut[addrIn]` takes `dataIn`, and every other bit becomes 0.
- R7: `rst`=1 at a rising edge makes all eight bits 0, whatever mode the other inputs select. The reset is synchronous and active-high.
- R8: Outputs change only at rising clock edges. A change on an input between edges leaves `latchOut` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all sampling happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all bits |
| dataIn | input | 1 | Data bit routed to the addressed cell |
| addrIn | input | 3 | Index of the cell to write |
| enableN | input | 1 | Active-low write enable |
| clearN | input | 1 | Active-low clear |
| latchOut | output | 8 | Stored bits; bit i belongs to address i |

## Verification
Every mode takes effect at the first rising edge that samples the new inputs, so each result is due exactly one edge after the stimulus. The bench drives inputs at the falling edge and then checks that `latchOut` still shows the old value just after the input change. It compares all eight bits with its own model 1 ns after the next rising edge. Capture on enable release is checked by raising the enable and then toggling data on later edges, so the stored bit must keep the value from the last enabled edge.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  // Mode encoding is {enableN, clearN} as sampled at the clock edge.
  typedef enum logic [1:0] {
    MODE_DECODE = 2'b00,
    MODE_WRITE  = 2'b01,
    MODE_CLEAR  = 2'b10,
    MODE_HOLD   = 2'b11
  } latch_mode_e;

  // Strobes from control to the bit cells.
  typedef struct packed {
    logic loadSel;   // addressed cell loads the data bit
    logic zeroSel;   // addressed cell is forced to zero
    logic zeroRest;  // every unaddressed cell is forced to zero
  } latch_strobe_t;

endpackage

// File: rtl/addr_latch_ctrl.sv
module addr_latch_ctrl
  import addr_latch_pkg::*;
(
  input  logic          enableN,
  input  logic          clearN,
  output latch_mode_e   mode,
  output latch_strobe_t strobe
);

  assign mode = latch_mode_e'({enableN, clearN});

  always_comb begin
    strobe = '0;
    unique case (mode)
      MODE_WRITE:  strobe.loadSel = 1'b1;
      MODE_DECODE: begin
        strobe.loadSel  = 1'b1;
        strobe.zeroRest = 1'b1;
      end
      MODE_CLEAR: begin
        strobe.zeroSel  = 1'b1;
        strobe.zeroRest = 1'b1;
      end
      default: strobe = '0;
    endcase
  end

  // R2/R5: the addressed cell is never told to load and clear at once.
  always_comb begin
    p_strobe_excl_r2: assert (!(strobe.loadSel && strobe.zeroSel))
      else $error("control asserted load and zero together");
  end

endmodule

// File: rtl/addr_latch_dp.sv
module addr_latch_dp
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NUM_OUT = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  latch_strobe_t      strobe,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               dataBit,
  output logic [NUM_OUT-1:0] q
);

  logic [NUM_OUT-1:0] nextQ;
  logic [NUM_OUT-1:0] selHot;

  // One cell per output bit: selected cells obey the load/zero strobes,
  // unselected cells hold unless told to clear.
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_cell
    assign selHot[i] = (addr == ADDR_W'(i));
    always_comb begin
      if (selHot[i]) begin
        if (strobe.loadSel)      nextQ[i] = dataBit;
        else if (strobe.zeroSel) nextQ[i] = 1'b0;
        else                     nextQ[i] = q[i];
      end else begin
        nextQ[i] = strobe.zeroRest ? 1'b0 : q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nextQ;
  end

  // R1: exactly one cell is selected by any address.
  always_comb begin
    p_one_sel_r1: assert ($onehot(selHot) || $isunknown(addr))
      else $error("address selects other than one cell");
  end

endmodule

// File: rtl/addressable_latch.sv
module addressable_latch
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NUM_OUT = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dataIn,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic               enableN,
  input  logic               clearN,
  output logic [NUM_OUT-1:0] latchOut
);

  latch_mode_e   mode;
  latch_strobe_t strobe;

  addr_latch_ctrl u_ctrl (
    .enableN (enableN),
    .clearN  (clearN),
    .mode    (mode),
    .strobe  (strobe)
  );

  addr_latch_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .addr    (addrIn),
    .dataBit (dataIn),
    .q       (latchOut)
  );

  localparam logic [NUM_OUT-1:0] ONE = NUM_OUT'(1);

  p_write_sel_r2: assert property (@(posedge clk) disable iff (rst)
    (!enableN && clearN) |=> latchOut[$past(addrIn)] == $past(dataIn));

  p_write_rest_r2: assert property (@(posedge clk) disable iff (rst)
    (!enableN && clearN) |=>
      ((latchOut ^ $past(latchOut)) & ~(ONE << $past(addrIn))) == '0);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (enableN && clearN) |=> $stable(latchOut));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (enableN && !clearN) |=> latchOut == '0);

  p_decode_r6: assert property (@(posedge clk) disable iff (rst)
    (!enableN && !clearN) |=>
      ($onehot0(latchOut) && latchOut[$past(addrIn)] == $past(dataIn)));

  p_reset_r7: assert property (@(posedge clk)
    rst |=> latchOut == '0);

endmodule

// File: tb/addressable_latch_tb.sv
module addressable_latch_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dataIn = 1'b0;
  logic [2:0] addrIn = '0;
  logic       enableN = 1'b1;
  logic       clearN = 1'b1;
  logic [7:0] latchOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] model = '0;

  always #10 clk = ~clk;

  addressable_latch u_dut (
    .clk(clk), .rst(rst), .dataIn(dataIn), .addrIn(addrIn),
    .enableN(enableN), .clearN(clearN), .latchOut(latchOut)
  );

  task automatic check(input string req, input logic [7:0] exp);
    total++;
    if (latchOut !== exp) begin
      bad++;
      $display("FAIL %s: latchOut=%b expected=%b at %0t", req, latchOut, exp, $time);
    end
  endtask

  // Model update from the requirements.
  function automatic logic [7:0] next_model(input logic [7:0] cur, input logic en,
                                            input logic cl, input logic [2:0] a,
                                            input logic d);
    logic [7:0] r;
    r = cur;
    case ({en, cl})
      2'b01: r[a] = d;                          // R2 write
      2'b11: r = cur;                           // R4 hold
      2'b10: r = '0;                            // R5 clear
      2'b00: begin r = '0; r[a] = d; end        // R6 decode
      default: r = cur;
    endcase
    return r;
  endfunction

  // Drive at falling edge, check no early change (R8), check after rising edge.
  task automatic step(input string req, input logic en, input logic cl,
                      input logic [2:0] a, input logic d);
    @(negedge clk);
    enableN = en; clearN = cl; addrIn = a; dataIn = d;
    #1 check("R8", model);
    @(posedge clk);
    #1;
    model = next_model(model, en, cl, a, d);
    check(req, model);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    @(posedge clk); #1 check("R7", 8'h00);
    @(negedge clk); rst = 1'b0;
    model = '0;
  endtask

  task automatic t_address_map;
    for (int i = 0; i < 8; i++) begin
      step("R5", 1'b1, 1'b0, 3'd0, 1'b0);
      step("R1", 1'b0, 1'b1, 3'(i), 1'b1);
      check("R1", 8'(1) << i);
    end
  endtask

  task automatic t_write;
    step("R5", 1'b1, 1'b0, 3'd0, 1'b0);
    for (int i = 0; i < 8; i++) step("R2", 1'b0, 1'b1, 3'(i), 1'(i % 3 != 0));
    for (int i = 7; i >= 0; i--) step("R2", 1'b0, 1'b1, 3'(i), 1'(i % 2));
    step("R2", 1'b1, 1'b1, 3'd0, 1'b0);
  endtask

  task automatic t_capture;
    step("R3", 1'b1, 1'b1, 3'd5, 1'b0);
    step("R3", 1'b0, 1'b1, 3'd5, 1'b0);
    step("R3", 1'b0, 1'b1, 3'd5, 1'b1);
    step("R3", 1'b1, 1'b1, 3'd5, 1'b0);
    step("R3", 1'b1, 1'b1, 3'd5, 1'b1);
    step("R3", 1'b1, 1'b1, 3'd5, 1'b0);
    check("R3", model);
    total++;
    if (latchOut[5] !== 1'b1) begin
      bad++;
      $display("FAIL R3: bit5=%b expected=1", latchOut[5]);
    end
  endtask

  task automatic t_hold;
    for (int i = 0; i < 16; i++) step("R4", 1'b1, 1'b1, 3'(i * 3), 1'(i));
  endtask

  task automatic t_clear;
    step("R2", 1'b0, 1'b1, 3'd2, 1'b1);
    step("R2", 1'b0, 1'b1, 3'd6, 1'b1);
    for (int i = 0; i < 8; i++) begin
      step("R2", 1'b0, 1'b1, 3'(7 - i), 1'b1);
      step("R5", 1'b1, 1'b0, 3'(i), 1'b1);
      check("R5", 8'h00);
    end
  endtask

  task automatic t_decode;
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 8; i++) begin
        step("R2", 1'b0, 1'b1, 3'(i ^ 3'd7), 1'b1);
        step("R6", 1'b0, 1'b0, 3'(i), 1'(d));
        check("R6", 8'(d) << i);
      end
  endtask

  task automatic t_reset_override;
    for (int m = 0; m < 4; m++) begin
      step("R2", 1'b0, 1'b1, 3'd3, 1'b1);
      @(negedge clk);
      rst = 1'b1; enableN = m[1]; clearN = m[0]; addrIn = 3'd1; dataIn = 1'b1;
      @(posedge clk); #1;
      model = '0;
      check("R7", 8'h00);
      @(negedge clk); rst = 1'b0; enableN = 1'b1; clearN = 1'b1;
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog: expired expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_address_map();
    t_write();
    t_capture();
    t_hold();
    t_clear();
    t_decode();
    t_reset_override();
    t_hold();
    finish_run();
  end

endmodule